// File: doc/BRIEF.md
# Divided Countdown Timer with Pending-Expiry Counter

The block is a local interval timer. A bus-cycle tick enters a power-of-two prescaler, and each prescaled step decrements a 32-bit count that starts from an initial value written by the host. When the count expires, a saturating pending-expiry counter is incremented. The timer runs either once or repeatedly, depending on a control word. That word also holds an 8-bit interrupt vector and a mask bit.

While the mask is clear and at least one expiry is pending, the block presents an interrupt request carrying the vector. The consumer acknowledges each injection, and each acknowledge removes one pending expiry.

Each register has a plain write strobe. The current count, the control word and the pending count are always visible as outputs. A software-enable level input masks the timer and discards pending expiries while it is low.

Top module: `dtmr_top`

## Requirements
- R1: After synchronous reset, the current count reads 0, the control word reads 0x0001_0000 (mask set), the pending count is 0 and no request is raised.
- R2: The divide ratio is 2^((({cfg[3],cfg[1:0]}) + 1) mod 8). Bit 2 is ignored, 0b1011 gives 1, 0b0000 gives 2 and 0b1010 gives 128. A count step happens after ratio clock cycles with `tick_i` high, and cycles with `tick_i` low do not advance the timer.
- R3: Writing the initial count shows the new value on `cur_count_o` in the next cycle. The write cancels the running period and restarts the prescaler from zero.
- R4: With an initial count of 0, the current count stays 0 and no expiry is ever recorded.
- R5: In one-shot mode (control bit 17 = 0), the step from 1 is the expiry and leaves the count at 0. The count then stays at 0 until the initial count is written again.
- R6: In periodic mode (control bit 17 = 1), the expiry step reloads the initial count instead of showing 0, and counting continues.
- R7: Each expiry adds one to the pending count, which saturates at 2^PEND_W-1.
- R8: `irq_valid_o` is high exactly when the mask (control bit 16) is clear and the pending count is nonzero, and `irq_vector_o` carries control bits 7:0. An acknowledge while the request is high removes one pending expiry. An acknowledge while the request is low is ignored. An expiry and an acknowledge in the same cycle leave the count unchanged.
- R9: The control word keeps only bits 7:0, 16 and 17, and all other bits read 0.
- R10: While `sw_en_i` is low, the mask bit is forced to 1 (including on a control write), the pending count is held at 0 and no expiry is counted.
- R11: A new divide configuration takes effect at the next prescaler terminal count. The period already in progress completes at the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Bus-cycle tick enabling the prescaler |
| sw_en_i | input | 1 | Software enable level |
| init_we_i | input | 1 | Initial-count write strobe |
| init_data_i | input | CNT_W | Initial count value |
| div_we_i | input | 1 | Divide-configuration write strobe |
| div_data_i | input | 4 | Divide configuration |
| ctl_we_i | input | 1 | Control-word write strobe |
| ctl_data_i | input | 32 | Control word value |
| irq_ack_i | input | 1 | Consumer accepted the request |
| cur_count_o | output | CNT_W | Current count |
| ctl_o | output | 32 | Stored control word |
| irq_valid_o | output | 1 | Interrupt request |
| irq_vector_o | output | 8 | Vector of the request |
| pending_o | output | PEND_W | Pending expirations |

## Verification
Register writes and acknowledges are visible on the outputs one clock after the edge that takes them. A count step or expiry appears one clock after the edge on which the ratio-th qualifying tick is taken. The request follows the pending count and the mask in that same cycle.

The bench drives every input just after a falling edge and reads the outputs at the next falling edge, so each check lands half a cycle after the edge that produced it. Divide ratios are checked one tick before the step and on the step itself, so an off-by-one in the prescaler shows up.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int VEC_W    = 8;
  localparam int CTL_W    = 32;
  localparam int MASK_BIT = 16;
  localparam int PER_BIT  = 17;
  localparam int DIV_W    = 4;
  localparam int SH_W     = 3;
  localparam int PRE_W    = 7;   // holds up to ratio 128 minus one
  localparam logic [CTL_W-1:0] CTL_KEEP  = 32'h0003_00FF;
  localparam logic [CTL_W-1:0] CTL_RESET = 32'h0001_0000;

  function automatic logic [SH_W-1:0] div_shift(input logic [DIV_W-1:0] c);
    return {c[3], c[1:0]} + 3'd1;
  endfunction
endpackage

// File: rtl/dtmr_prescale.sv
module dtmr_prescale
  import dtmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             cfg_we_i,
  input  logic [DIV_W-1:0] cfg_i,
  output logic             strobe_o
);
  logic [DIV_W-1:0] cfg_q;
  logic [SH_W-1:0]  act_sh_q;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;
  logic             term;

  always_comb begin
    limit = PRE_W'((1 << act_sh_q) - 1);
    term  = (pre_q == limit);
  end

  assign strobe_o = tick_i & term & ~restart_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      act_sh_q <= div_shift('0);
      pre_q    <= '0;
    end else begin
      if (cfg_we_i) cfg_q <= cfg_i;
      if (restart_i) begin
        pre_q    <= '0;
        act_sh_q <= div_shift(cfg_q);
      end else if (tick_i) begin
        if (term) begin
          pre_q    <= '0;
          act_sh_q <= div_shift(cfg_q);
        end else begin
          pre_q <= pre_q + PRE_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dtmr_core.sv
module dtmr_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  input  logic             periodic_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] init_q;
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = step_i & ~load_i & (cnt_q == CNT_W'(1));
  assign count_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      init_q <= load_val_i;
      cnt_q  <= load_val_i;
    end else if (step_i && cnt_q != '0) begin
      if (cnt_q == CNT_W'(1)) cnt_q <= periodic_i ? init_q : '0;
      else                    cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/dtmr_pending.sv
module dtmr_pending #(
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              inc_i,
  input  logic              dec_i,
  output logic [PEND_W-1:0] count_o
);
  localparam logic [PEND_W-1:0] MAX = '1;
  logic [PEND_W-1:0] cnt_q;

  assign count_o = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (inc_i && !dec_i) begin
      if (cnt_q != MAX) cnt_q <= cnt_q + PEND_W'(1);
    end else if (dec_i && !inc_i) begin
      if (cnt_q != '0) cnt_q <= cnt_q - PEND_W'(1);
    end
  end
endmodule

// File: rtl/dtmr_top.sv
module dtmr_top
  import dtmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              sw_en_i,
  input  logic              init_we_i,
  input  logic [CNT_W-1:0]  init_data_i,
  input  logic              div_we_i,
  input  logic [3:0]        div_data_i,
  input  logic              ctl_we_i,
  input  logic [31:0]       ctl_data_i,
  input  logic              irq_ack_i,
  output logic [CNT_W-1:0]  cur_count_o,
  output logic [31:0]       ctl_o,
  output logic              irq_valid_o,
  output logic [7:0]        irq_vector_o,
  output logic [PEND_W-1:0] pending_o
);
  logic [CTL_W-1:0]  ctl_q;
  logic              step;
  logic              expire;
  logic              take;
  logic [PEND_W-1:0] pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= CTL_RESET;
    end else if (ctl_we_i) begin
      ctl_q <= (ctl_data_i & CTL_KEEP) | (sw_en_i ? '0 : CTL_RESET);
    end else if (!sw_en_i) begin
      ctl_q[MASK_BIT] <= 1'b1;
    end
  end

  dtmr_prescale u_pre (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .restart_i (init_we_i),
    .cfg_we_i  (div_we_i),
    .cfg_i     (div_data_i),
    .strobe_o  (step)
  );

  dtmr_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .load_i     (init_we_i),
    .load_val_i (init_data_i),
    .step_i     (step),
    .periodic_i (ctl_q[PER_BIT]),
    .count_o    (cur_count_o),
    .expire_o   (expire)
  );

  assign irq_valid_o  = (pend != '0) && !ctl_q[MASK_BIT];
  assign irq_vector_o = ctl_q[VEC_W-1:0];
  assign take         = irq_ack_i & irq_valid_o;

  dtmr_pending #(.PEND_W(PEND_W)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (!sw_en_i),
    .inc_i   (expire),
    .dec_i   (take),
    .count_o (pend)
  );

  assign pending_o = pend;
  assign ctl_o     = ctl_q;
endmodule

// File: rtl/dtmr_check.sv
module dtmr_check #(
  parameter int CNT_W  = 32,
  parameter int PEND_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              sw_en_i,
  input logic              init_we_i,
  input logic [CNT_W-1:0]  init_data_i,
  input logic              irq_ack_i,
  input logic [CNT_W-1:0]  cur_count_o,
  input logic [31:0]       ctl_o,
  input logic              irq_valid_o,
  input logic [PEND_W-1:0] pending_o
);
  localparam logic [PEND_W-1:0] PMAX = '1;

  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    init_we_i |=> cur_count_o == $past(init_data_i));

  p_zero_stays_r5: assert property (@(posedge clk) disable iff (rst)
    (cur_count_o == '0 && !init_we_i) |=> cur_count_o == '0);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (sw_en_i && pending_o == PMAX && !(irq_ack_i && irq_valid_o)) |=> pending_o == PMAX);

  p_ack_r8: assert property (@(posedge clk) disable iff (rst)
    (sw_en_i && irq_valid_o && irq_ack_i) |=>
      (pending_o == $past(pending_o) || pending_o == $past(pending_o) - PEND_W'(1)));

  p_masked_r8: assert property (@(posedge clk) disable iff (rst)
    ctl_o[16] |-> !irq_valid_o);

  p_fields_r9: assert property (@(posedge clk) disable iff (rst)
    (ctl_o[31:18] == '0 && ctl_o[15:8] == '0));

  p_disable_r10: assert property (@(posedge clk) disable iff (rst)
    !sw_en_i |=> (pending_o == '0 && ctl_o[16]));
endmodule

bind dtmr_top dtmr_check #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sw_en_i     (sw_en_i),
  .init_we_i   (init_we_i),
  .init_data_i (init_data_i),
  .irq_ack_i   (irq_ack_i),
  .cur_count_o (cur_count_o),
  .ctl_o       (ctl_o),
  .irq_valid_o (irq_valid_o),
  .pending_o   (pending_o)
);

// File: tb/dtmr_top_test.sv
module dtmr_top_test;
  localparam int CW = 32;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, sw_en = 1'b0, init_we = 1'b0, div_we = 1'b0, ctl_we = 1'b0, ack = 1'b0;
  logic [CW-1:0] init_data = '0;
  logic [3:0]    div_data = '0;
  logic [31:0]   ctl_data = '0;
  logic [CW-1:0] cur;
  logic [31:0]   ctl;
  logic          valid;
  logic [7:0]    vec;
  logic [PW-1:0] pend;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  dtmr_top #(.CNT_W(CW), .PEND_W(PW)) uut (
    .clk(clk), .rst(rst), .tick_i(tick), .sw_en_i(sw_en),
    .init_we_i(init_we), .init_data_i(init_data),
    .div_we_i(div_we), .div_data_i(div_data),
    .ctl_we_i(ctl_we), .ctl_data_i(ctl_data), .irq_ack_i(ack),
    .cur_count_o(cur), .ctl_o(ctl), .irq_valid_o(valid),
    .irq_vector_o(vec), .pending_o(pend)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); @(negedge clk); endtask
  task automatic ticks(input int n); tick = 1'b1; repeat (n) cyc(); tick = 1'b0; endtask
  task automatic wr_init(input logic [31:0] v); init_we = 1'b1; init_data = v; cyc(); init_we = 1'b0; endtask
  task automatic wr_div(input logic [3:0] v); div_we = 1'b1; div_data = v; cyc(); div_we = 1'b0; endtask
  task automatic wr_ctl(input logic [31:0] v); ctl_we = 1'b1; ctl_data = v; cyc(); ctl_we = 1'b0; endtask
  task automatic do_ack(); ack = 1'b1; cyc(); ack = 1'b0; endtask
  task automatic flush(); sw_en = 1'b0; cyc(); sw_en = 1'b1; endtask

  task automatic t_reset();
    repeat (2) cyc();
    rst = 1'b0;
    cyc();
    chk("R1 count", cur, 0);
    chk("R1 ctl", ctl, 32'h0001_0000);
    chk("R1 pending", 32'(pend), 0);
    chk("R1 request", 32'(valid), 0);
    sw_en = 1'b1;
  endtask

  task automatic t_ctl_fields();
    wr_ctl(32'hFFFF_FFFF);
    chk("R9 kept bits", ctl, 32'h0003_00FF);
    wr_ctl(32'h0000_0040);
    chk("R9 plain write", ctl, 32'h0000_0040);
  endtask

  task automatic t_oneshot();
    wr_div(4'hB);
    wr_ctl(32'h0000_0040);
    wr_init(5);
    chk("R3 load", cur, 5);
    ticks(4);
    chk("R5 before expiry", cur, 1);
    chk("R7 no early expiry", 32'(pend), 0);
    ticks(1);
    chk("R5 expired", cur, 0);
    chk("R7 pending one", 32'(pend), 1);
    chk("R8 request", 32'(valid), 1);
    chk("R8 vector", 32'(vec), 32'h40);
    ticks(3);
    chk("R5 stays zero", cur, 0);
    do_ack();
    chk("R8 ack drains", 32'(pend), 0);
    chk("R8 request drops", 32'(valid), 0);
    do_ack();
    chk("R8 idle ack ignored", 32'(pend), 0);
  endtask

  task automatic t_periodic();
    wr_ctl(32'h0002_0041);
    wr_init(3);
    ticks(1);
    chk("R6 counting", cur, 2);
    ticks(2);
    chk("R6 reload", cur, 3);
    chk("R7 first expiry", 32'(pend), 1);
    ticks(3);
    chk("R6 reload again", cur, 3);
    chk("R7 second expiry", 32'(pend), 2);
    ticks(2);
    tick = 1'b1; ack = 1'b1; cyc(); tick = 1'b0; ack = 1'b0;
    chk("R8 expiry with ack", 32'(pend), 2);
    flush();
    chk("R10 pending cleared", 32'(pend), 0);
    chk("R10 mask forced", 32'(ctl[16]), 1);
  endtask

  task automatic t_zero();
    wr_ctl(32'h0002_0041);
    wr_init(0);
    ticks(20);
    chk("R4 count zero", cur, 0);
    chk("R4 no expiry", 32'(pend), 0);
  endtask

  task automatic t_div_ratio();
    logic [3:0] cfgs [8] = '{4'h0, 4'h4, 4'h1, 4'h7, 4'h8, 4'hA, 4'hB, 4'hF};
    wr_ctl(32'h0000_0040);
    foreach (cfgs[i]) begin
      int sh = ({cfgs[i][3], cfgs[i][1:0]} + 1) % 8;
      int r = 1 << sh;
      wr_div(cfgs[i]);
      wr_init(1000);
      if (r > 1) begin
        ticks(r - 1);
        chk($sformatf("R2 cfg %0h before step", cfgs[i]), cur, 1000);
      end
      ticks(1);
      chk($sformatf("R2 cfg %0h step", cfgs[i]), cur, 999);
      repeat (5) cyc();
      chk("R2 idle ticks", cur, 999);
    end
  endtask

  task automatic t_div_change();
    wr_div(4'h1);
    wr_init(100);
    ticks(3);
    chk("R11 ratio four", cur, 100);
    ticks(1);
    chk("R11 step", cur, 99);
    ticks(1);
    wr_div(4'hB);
    ticks(2);
    chk("R11 old period runs", cur, 99);
    ticks(1);
    chk("R11 old period ends", cur, 98);
    ticks(1);
    chk("R11 new ratio", cur, 97);
  endtask

  task automatic t_restart();
    wr_ctl(32'h0001_0040);
    wr_init(10);
    ticks(4);
    chk("R3 running", cur, 6);
    wr_init(7);
    chk("R3 restart", cur, 7);
    ticks(1);
    chk("R3 after restart", cur, 6);
  endtask

  task automatic t_mask();
    flush();
    wr_ctl(32'h0001_0040);
    wr_init(2);
    ticks(2);
    chk("R7 masked expiry", 32'(pend), 1);
    chk("R8 masked no request", 32'(valid), 0);
    do_ack();
    chk("R8 masked ack ignored", 32'(pend), 1);
    wr_ctl(32'h0000_0040);
    chk("R8 unmask request", 32'(valid), 1);
    do_ack();
    chk("R8 ack after unmask", 32'(pend), 0);
  endtask

  task automatic t_sat();
    flush();
    wr_ctl(32'h0003_0040);
    wr_init(1);
    ticks(20);
    chk("R7 saturate", 32'(pend), (1 << PW) - 1);
    sw_en = 1'b0;
    wr_ctl(32'h0000_0040);
    chk("R10 write forces mask", ctl, 32'h0001_0040);
    ticks(3);
    chk("R10 no count when off", 32'(pend), 0);
    sw_en = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_ctl_fields();
    t_oneshot();
    t_periodic();
    t_zero();
    t_div_ratio();
    t_div_change();
    t_restart();
    t_mask();
    t_sat();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule